// File: doc/BRIEF.md
# Deferred-Write Store Buffer (one entry, with load forwarding)

This block sits beside a data cache in the memory stage of a pipeline. A store whose tag check hits does not write the data array in its own cycle. Its word address, data, byte enables and the hit way found by the tag check are parked in a single buffer entry. The parked store is written to the data array later, using the recorded way and with no second tag check. The write happens when the next hitting store arrives, when a load conflict or any miss needs the buffer empty, or when an explicit drain is requested.

Loads look up the entry in the same cycle as their own tag check. A load to the same word whose requested bytes are all covered by the parked store gets the data forwarded from the buffer. A load that needs a byte the parked store did not write is stalled, and the entry is pushed out to the array. A miss, from a load or a store, is not allowed to start its fill while a store is parked, because the deferred write would land in a way that the fill may replace.

The store-in port and the array write port are valid/ready. A store is taken only on a cycle with `sd_valid`, `sd_hit` and `sd_ready` all high. `sd_ready` is low for a store that missed. It is also low while a parked store cannot leave because `arr_ready` is low. `arr_valid`, once raised, keeps its payload stable until `arr_ready` is seen. The load port, drain request, drain completion and fill permission are plain level signals evaluated in the same cycle.

Top module: `store_defer_buf`

## Requirements
- R1: A hitting store offered while the buffer is empty has `sd_ready` high and is captured. From the next cycle its address, data, byte enables and way appear on `arr_addr`, `arr_data`, `arr_be`, `arr_way` when a write is issued.
- R2: A store with `sd_hit` low is never accepted (`sd_ready` low). It forces out any parked store, and `fill_go` rises only on a cycle when the buffer is empty.
- R3: A hitting store that meets an occupied buffer writes the old entry in the same cycle it is accepted. While `arr_ready` is low it is held off with `sd_ready` low.
- R4: The array write carries the way recorded at the store's tag check, not a value derived from any later input.
- R5: A hitting load with the same full word address as the parked store, whose byte enables are a subset of the store's, gets `ld_fwd` high. `ld_fwd_data` holds the parked data with every byte lane the load did not request forced to zero. Lane i is bits 8i+7:8i, enabled by bit i.
- R6: A hitting load to the parked word that requests any byte the store did not write gets `ld_stall` high and no forwarding. The parked store is pushed to the array, and the stall clears once the buffer is empty.
- R7: A load to a different word address sees neither forward nor stall, and does not by itself cause a write.
- R8: A load with `ld_hit` low forces out a parked store. `fill_go` stays low until the cycle after that write completes.
- R9: `drain_req` with an empty buffer raises `drain_done` in the same cycle. With a parked store it issues the write, and `drain_done` follows once the buffer is empty.
- R10: Reset empties the buffer: after reset no write is issued, and `drain_done` answers a drain request at once.
- R11: While `arr_valid` is high and `arr_ready` is low, the write payload and the buffer contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sd_valid | input | 1 | Store present in the memory stage |
| sd_ready | output | 1 | Store accepted into the buffer this cycle |
| sd_hit | input | 1 | Tag check result for the store |
| sd_way | input | WAY_W | Way that hit for the store |
| sd_addr | input | ADDR_W | Store word address |
| sd_data | input | DATA_W | Store data |
| sd_be | input | DATA_W/8 | Store byte enables |
| ld_valid | input | 1 | Load present in the memory stage |
| ld_hit | input | 1 | Tag check result for the load |
| ld_addr | input | ADDR_W | Load word address |
| ld_be | input | DATA_W/8 | Bytes the load needs |
| ld_fwd | output | 1 | Load served from the buffer |
| ld_fwd_data | output | DATA_W | Forwarded data, unrequested lanes zero |
| ld_stall | output | 1 | Load conflicts with the parked store |
| fill_go | output | 1 | A pending miss may start its fill |
| drain_req | input | 1 | Request to empty the buffer |
| drain_done | output | 1 | Buffer is empty while a drain is requested |
| arr_valid | output | 1 | Data-array write request |
| arr_ready | input | 1 | Data array takes the write |
| arr_addr | output | ADDR_W | Write word address |
| arr_way | output | WAY_W | Write way |
| arr_data | output | DATA_W | Write data |
| arr_be | output | DATA_W/8 | Write byte enables |

## Verification
The case of interest is a new hitting store that arrives while a store is already parked. The array write of the old entry and the capture of the new one then fall in one cycle, and the bench also puts a matching load in that same cycle. The bench checks that the write port shows the old address, way and data. The load must be forwarded the old data. On the following cycle the load must see the new entry, with its way and its narrower byte enables. A second pairing holds the same store back with `arr_ready` low and checks that neither the payload nor acceptance moves until the array takes the write.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

  // Outcome of looking a load up against the parked store
  typedef enum logic [1:0] {
    LK_NONE  = 2'd0,
    LK_FWD   = 2'd1,
    LK_STALL = 2'd2,
    LK_MISS  = 2'd3
  } lookup_e;

endpackage

// File: rtl/sdb_entry.sv
module sdb_entry #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int WAY_W  = 2,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              release_i,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BE_W-1:0]   in_be,
  input  logic [WAY_W-1:0]  in_way,
  output logic              occ,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_data,
  output logic [BE_W-1:0]   q_be,
  output logic [WAY_W-1:0]  q_way
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= 1'b0;
    end else if (capture) begin
      occ <= 1'b1;
    end else if (release_i) begin
      occ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      q_addr <= in_addr;
      q_data <= in_data;
      q_be   <= in_be;
      q_way  <= in_way;
    end
  end

endmodule

// File: rtl/sdb_match.sv
module sdb_match
  import sdb_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              occ,
  input  logic [ADDR_W-1:0] ent_addr,
  input  logic [DATA_W-1:0] ent_data,
  input  logic [BE_W-1:0]   ent_be,
  input  logic              ld_valid,
  input  logic              ld_hit,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BE_W-1:0]   ld_be,
  output lookup_e           kind,
  output logic [DATA_W-1:0] fwd_data
);

  logic [DATA_W-1:0] lane_mask;
  logic              same_word;
  logic              covered;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign lane_mask[8*b +: 8] = {8{ld_be[b]}};
  end

  assign same_word = occ && (ld_addr == ent_addr);
  assign covered   = ((ld_be & ~ent_be) == '0);
  assign fwd_data  = ent_data & lane_mask;

  always_comb begin
    kind = LK_NONE;
    if (ld_valid) begin
      if (!ld_hit)        kind = LK_MISS;
      else if (same_word) kind = covered ? LK_FWD : LK_STALL;
    end
  end

endmodule

// File: rtl/sdb_drain_ctl.sv
module sdb_drain_ctl
  import sdb_pkg::*;
(
  input  logic    occ,
  input  logic    sd_valid,
  input  logic    sd_hit,
  input  lookup_e kind,
  input  logic    drain_req,
  input  logic    arr_ready,
  output logic    arr_valid,
  output logic    write_fire,
  output logic    sd_ready,
  output logic    capture,
  output logic    fill_go,
  output logic    drain_done
);

  logic store_miss;
  logic load_miss;
  logic must_leave;

  assign store_miss = sd_valid && !sd_hit;
  assign load_miss  = (kind == LK_MISS);

  // Any of these needs the parked store out of the way
  assign must_leave = (sd_valid && sd_hit) || store_miss || load_miss ||
                      (kind == LK_STALL) || drain_req;

  assign arr_valid  = occ && must_leave;
  assign write_fire = arr_valid && arr_ready;

  // A hitting store enters when the slot is free or is freed this cycle
  assign sd_ready   = sd_hit && (!occ || arr_ready);
  assign capture    = sd_valid && sd_ready;

  // Fills wait until nothing is parked
  assign fill_go    = (store_miss || load_miss) && !occ;
  assign drain_done = drain_req && !occ;

endmodule

// File: rtl/store_defer_buf.sv
module store_defer_buf
  import sdb_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd_valid,
  output logic              sd_ready,
  input  logic              sd_hit,
  input  logic [WAY_W-1:0]  sd_way,
  input  logic [ADDR_W-1:0] sd_addr,
  input  logic [DATA_W-1:0] sd_data,
  input  logic [BE_W-1:0]   sd_be,
  input  logic              ld_valid,
  input  logic              ld_hit,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BE_W-1:0]   ld_be,
  output logic              ld_fwd,
  output logic [DATA_W-1:0] ld_fwd_data,
  output logic              ld_stall,
  output logic              fill_go,
  input  logic              drain_req,
  output logic              drain_done,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [WAY_W-1:0]  arr_way,
  output logic [DATA_W-1:0] arr_data,
  output logic [BE_W-1:0]   arr_be
);

  logic    occ;
  logic    capture;
  logic    write_fire;
  lookup_e kind;

  sdb_entry #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAY_W(WAY_W)
  ) u_entry (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .release_i(write_fire),
    .in_addr  (sd_addr),
    .in_data  (sd_data),
    .in_be    (sd_be),
    .in_way   (sd_way),
    .occ      (occ),
    .q_addr   (arr_addr),
    .q_data   (arr_data),
    .q_be     (arr_be),
    .q_way    (arr_way)
  );

  sdb_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_match (
    .occ     (occ),
    .ent_addr(arr_addr),
    .ent_data(arr_data),
    .ent_be  (arr_be),
    .ld_valid(ld_valid),
    .ld_hit  (ld_hit),
    .ld_addr (ld_addr),
    .ld_be   (ld_be),
    .kind    (kind),
    .fwd_data(ld_fwd_data)
  );

  sdb_drain_ctl u_ctl (
    .occ       (occ),
    .sd_valid  (sd_valid),
    .sd_hit    (sd_hit),
    .kind      (kind),
    .drain_req (drain_req),
    .arr_ready (arr_ready),
    .arr_valid (arr_valid),
    .write_fire(write_fire),
    .sd_ready  (sd_ready),
    .capture   (capture),
    .fill_go   (fill_go),
    .drain_done(drain_done)
  );

  assign ld_fwd   = (kind == LK_FWD);
  assign ld_stall = (kind == LK_STALL);

endmodule

// File: rtl/store_defer_buf_chk.sv
module store_defer_buf_chk #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int WAY_W  = 2,
  localparam int BE_W  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_valid,
  input logic              sd_ready,
  input logic              sd_hit,
  input logic [WAY_W-1:0]  sd_way,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [DATA_W-1:0] sd_data,
  input logic              ld_fwd,
  input logic              ld_stall,
  input logic              fill_go,
  input logic              drain_done,
  input logic              arr_valid,
  input logic              arr_ready,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [WAY_W-1:0]  arr_way,
  input logic [DATA_W-1:0] arr_data
);

  // R1 R4
  capture_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_valid && sd_hit && sd_ready) |=>
      (arr_addr == $past(sd_addr) && arr_way == $past(sd_way) &&
       arr_data == $past(sd_data)));

  // R2
  miss_never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_valid && !sd_hit) |-> !sd_ready);

  // R3
  swap_needs_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_valid && sd_ready && arr_valid) |-> arr_ready);

  // R5
  fwd_or_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_fwd, ld_stall}));

  // R6
  stall_pushes_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> arr_valid);

  // R8
  fill_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |-> !arr_valid);

  // R9
  done_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> !arr_valid);

  // R11
  payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && !arr_ready) |=>
      ($stable(arr_addr) && $stable(arr_data) && $stable(arr_way)));

endmodule

bind store_defer_buf store_defer_buf_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAY_W(WAY_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sd_valid  (sd_valid),
  .sd_ready  (sd_ready),
  .sd_hit    (sd_hit),
  .sd_way    (sd_way),
  .sd_addr   (sd_addr),
  .sd_data   (sd_data),
  .ld_fwd    (ld_fwd),
  .ld_stall  (ld_stall),
  .fill_go   (fill_go),
  .drain_done(drain_done),
  .arr_valid (arr_valid),
  .arr_ready (arr_ready),
  .arr_addr  (arr_addr),
  .arr_way   (arr_way),
  .arr_data  (arr_data)
);

// File: tb/store_defer_buf_bench.sv
module store_defer_buf_bench;

  localparam int ADDR_W = 30;
  localparam int DATA_W = 32;
  localparam int WAY_W  = 2;
  localparam int BE_W   = 4;

  typedef struct packed {
    logic        sv, sh;
    logic [7:0]  sa;
    logic [31:0] sd;
    logic [3:0]  sb;
    logic [1:0]  sw;
    logic        lv, lh;
    logic [7:0]  la;
    logic [3:0]  lb;
    logic        dr, rdy;
    logic        e_sr, e_wv;
    logic [7:0]  e_wa;
    logic [1:0]  e_ww;
    logic [31:0] e_wd;
    logic [3:0]  e_wb;
    logic        e_fw;
    logic [31:0] e_fd;
    logic        e_stl, e_fg, e_dd;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    // idle
    '{0,0,8'h00,32'h0,4'h0,2'd0, 0,0,8'h00,4'h0, 0,1, 0,0,8'h00,2'd0,32'h0,4'h0, 0,32'h0,0,0,0},
    // R1 store hit into empty slot
    '{1,1,8'h10,32'hAABBCCDD,4'hF,2'd2, 0,0,8'h00,4'h0, 0,1, 1,0,8'h00,2'd0,32'h0,4'h0, 0,32'h0,0,0,0},
    // R5 full forward
    '{0,0,8'h00,32'h0,4'h0,2'd0, 1,1,8'h10,4'hF, 0,1, 0,0,8'h00,2'd0,32'h0,4'h0, 1,32'hAABBCCDD,0,0,0},
    // R5 subset forward, upper lanes zero
    '{0,0,8'h00,32'h0,4'h0,2'd0, 1,1,8'h10,4'h3, 0,1, 0,0,8'h00,2'd0,32'h0,4'h0, 1,32'h0000CCDD,0,0,0},
    // R7 other word
    '{0,0,8'h00,32'h0,4'h0,2'd0, 1,1,8'h11,4'hF, 0,1, 0,0,8'h00,2'd0,32'h0,4'h0, 0,32'h0,0,0,0},
    // R3 R4 swap plus matching load in the same cycle
    '{1,1,8'h20,32'h11223344,4'h3,2'd1, 1,1,8'h10,4'hF, 0,1, 1,1,8'h10,2'd2,32'hAABBCCDD,4'hF, 1,32'hAABBCCDD,0,0,0},
    // R6 R11 partial overlap, array busy
    '{0,0,8'h00,32'h0,4'h0,2'd0, 1,1,8'h20,4'hF, 0,0, 0,1,8'h20,2'd1,32'h11223344,4'h3, 0,32'h0,1,0,0},
    // R6 partial overlap, array takes it
    '{0,0,8'h00,32'h0,4'h0,2'd0, 1,1,8'h20,4'hF, 0,1, 0,1,8'h20,2'd1,32'h11223344,4'h3, 0,32'h0,1,0,0},
    // R6 stall gone once empty
    '{0,0,8'h00,32'h0,4'h0,2'd0, 1,1,8'h20,4'hF, 0,1, 0,0,8'h00,2'd0,32'h0,4'h0, 0,32'h0,0,0,0},
    // R1 new capture
    '{1,1,8'h30,32'hCAFEF00D,4'hF,2'd3, 0,0,8'h00,4'h0, 0,1, 1,0,8'h00,2'd0,32'h0,4'h0, 0,32'h0,0,0,0},
    // R3 R11 store held off by busy array
    '{1,1,8'h40,32'h01020304,4'hC,2'd0, 0,0,8'h00,4'h0, 0,0, 0,1,8'h30,2'd3,32'hCAFEF00D,4'hF, 0,32'h0,0,0,0},
    // R3 array ready, swap happens
    '{1,1,8'h40,32'h01020304,4'hC,2'd0, 0,0,8'h00,4'h0, 0,1, 1,1,8'h30,2'd3,32'hCAFEF00D,4'hF, 0,32'h0,0,0,0},
    // R8 load miss drains first
    '{0,0,8'h00,32'h0,4'h0,2'd0, 1,0,8'h55,4'hF, 0,1, 0,1,8'h40,2'd0,32'h01020304,4'hC, 0,32'h0,0,0,0},
    // R8 fill permitted next cycle
    '{0,0,8'h00,32'h0,4'h0,2'd0, 1,0,8'h55,4'hF, 0,1, 0,0,8'h00,2'd0,32'h0,4'h0, 0,32'h0,0,1,0},
    // R1 capture
    '{1,1,8'h60,32'h5A5A5A5A,4'hF,2'd1, 0,0,8'h00,4'h0, 0,1, 1,0,8'h00,2'd0,32'h0,4'h0, 0,32'h0,0,0,0},
    // R2 store miss forces write, no fill yet
    '{1,0,8'h70,32'h99999999,4'hF,2'd2, 0,0,8'h00,4'h0, 0,1, 0,1,8'h60,2'd1,32'h5A5A5A5A,4'hF, 0,32'h0,0,0,0},
    // R2 store miss, fill permitted
    '{1,0,8'h70,32'h99999999,4'hF,2'd2, 0,0,8'h00,4'h0, 0,1, 0,0,8'h00,2'd0,32'h0,4'h0, 0,32'h0,0,1,0},
    // R1 capture of a one-byte store
    '{1,1,8'h61,32'h00000077,4'h1,2'd0, 0,0,8'h00,4'h0, 0,1, 1,0,8'h00,2'd0,32'h0,4'h0, 0,32'h0,0,0,0},
    // R9 drain with entry
    '{0,0,8'h00,32'h0,4'h0,2'd0, 0,0,8'h00,4'h0, 1,1, 0,1,8'h61,2'd0,32'h00000077,4'h1, 0,32'h0,0,0,0},
    // R9 drain now complete
    '{0,0,8'h00,32'h0,4'h0,2'd0, 0,0,8'h00,4'h0, 1,1, 0,0,8'h00,2'd0,32'h0,4'h0, 0,32'h0,0,0,1}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sd_valid, sd_ready, sd_hit;
  logic [WAY_W-1:0]  sd_way;
  logic [ADDR_W-1:0] sd_addr;
  logic [DATA_W-1:0] sd_data;
  logic [BE_W-1:0]   sd_be;
  logic              ld_valid, ld_hit;
  logic [ADDR_W-1:0] ld_addr;
  logic [BE_W-1:0]   ld_be;
  logic              ld_fwd, ld_stall, fill_go;
  logic [DATA_W-1:0] ld_fwd_data;
  logic              drain_req, drain_done;
  logic              arr_valid, arr_ready;
  logic [ADDR_W-1:0] arr_addr;
  logic [WAY_W-1:0]  arr_way;
  logic [DATA_W-1:0] arr_data;
  logic [BE_W-1:0]   arr_be;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  store_defer_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(4)) u_store_defer_buf (
    .clk(clk), .rst_n(rst_n),
    .sd_valid(sd_valid), .sd_ready(sd_ready), .sd_hit(sd_hit), .sd_way(sd_way),
    .sd_addr(sd_addr), .sd_data(sd_data), .sd_be(sd_be),
    .ld_valid(ld_valid), .ld_hit(ld_hit), .ld_addr(ld_addr), .ld_be(ld_be),
    .ld_fwd(ld_fwd), .ld_fwd_data(ld_fwd_data), .ld_stall(ld_stall),
    .fill_go(fill_go), .drain_req(drain_req), .drain_done(drain_done),
    .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_addr(arr_addr),
    .arr_way(arr_way), .arr_data(arr_data), .arr_be(arr_be)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sd_valid = 0; sd_hit = 0; sd_way = '0; sd_addr = '0; sd_data = '0; sd_be = '0;
    ld_valid = 0; ld_hit = 0; ld_addr = '0; ld_be = '0;
    drain_req = 0; arr_ready = 1;
  endtask

  task automatic apply(input vec_t v);
    sd_valid = v.sv; sd_hit = v.sh; sd_addr = ADDR_W'(v.sa); sd_data = v.sd;
    sd_be = v.sb; sd_way = v.sw;
    ld_valid = v.lv; ld_hit = v.lh; ld_addr = ADDR_W'(v.la); ld_be = v.lb;
    drain_req = v.dr; arr_ready = v.rdy;
  endtask

  task automatic judge(input int i, input vec_t v);
    string tag;
    tag = $sformatf("vec%0d", i);
    chk(tag, "sd_ready R1/R2/R3", 32'(sd_ready), 32'(v.e_sr));
    chk(tag, "arr_valid R3/R6/R8/R9", 32'(arr_valid), 32'(v.e_wv));
    if (v.e_wv) begin
      chk(tag, "arr_addr R1", 32'(arr_addr), 32'(v.e_wa));
      chk(tag, "arr_way R4", 32'(arr_way), 32'(v.e_ww));
      chk(tag, "arr_data R1", arr_data, v.e_wd);
      chk(tag, "arr_be R1", 32'(arr_be), 32'(v.e_wb));
    end
    chk(tag, "ld_fwd R5/R7", 32'(ld_fwd), 32'(v.e_fw));
    if (v.e_fw) chk(tag, "ld_fwd_data R5", ld_fwd_data, v.e_fd);
    chk(tag, "ld_stall R6/R7", 32'(ld_stall), 32'(v.e_stl));
    chk(tag, "fill_go R2/R8", 32'(fill_go), 32'(v.e_fg));
    chk(tag, "drain_done R9", 32'(drain_done), 32'(v.e_dd));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R10 reset state: nothing parked, drain answered at once
    drain_req = 1;
    #2;
    chk("R10", "arr_valid after reset", 32'(arr_valid), 32'd0);
    chk("R10", "drain_done after reset", 32'(drain_done), 32'd1);
    chk("R10", "fill_go idle", 32'(fill_go), 32'd0);
    drain_req = 0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      #2;
      judge(i, VECS[i]);
    end

    // R10 reset while a store is parked
    @(negedge clk);
    idle_inputs();
    sd_valid = 1; sd_hit = 1; sd_addr = 30'h88; sd_data = 32'h12345678; sd_be = 4'hF;
    @(negedge clk);
    idle_inputs();
    ld_valid = 1; ld_hit = 1; ld_addr = 30'h88; ld_be = 4'hF;
    #2;
    chk("R5", "parked before reset", 32'(ld_fwd), 32'd1);
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    drain_req = 1; ld_valid = 1; ld_hit = 1; ld_addr = 30'h88; ld_be = 4'hF;
    #2;
    chk("R10", "drain_done after mid reset", 32'(drain_done), 32'd1);
    chk("R10", "no forward after reset", 32'(ld_fwd), 32'd0);
    chk("R10", "no write after reset", 32'(arr_valid), 32'd0);

    // R7 load to another word does not push the entry out
    @(negedge clk);
    idle_inputs();
    sd_valid = 1; sd_hit = 1; sd_addr = 30'h90; sd_data = 32'hDEADBEEF; sd_be = 4'hF; sd_way = 2'd3;
    @(negedge clk);
    idle_inputs();
    ld_valid = 1; ld_hit = 1; ld_addr = 30'h91; ld_be = 4'hF;
    #2;
    chk("R7", "no write for unrelated load", 32'(arr_valid), 32'd0);
    @(negedge clk);
    idle_inputs();
    ld_valid = 1; ld_hit = 1; ld_addr = 30'h90; ld_be = 4'h8;
    #2;
    chk("R7", "entry kept after unrelated load", 32'(ld_fwd), 32'd1);
    chk("R5", "top lane only", ld_fwd_data, 32'hDE000000);

    @(negedge clk);
    idle_inputs();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule